// File: doc/BRIEF.md
# Out-of-Order Block Fetch Sequencer

This block sits between a next-block predictor and the instruction cache. Each cycle it sends one block address to the cache. When the cache answers with a hit, the block is handed downstream in the following cycle, together with a sequence tag that records its place in program order. When the cache misses, the block is not waited for. The sequencer parks its address and tag in a small table and goes straight on with the next predicted address. The predictor does not need the missing block's contents to produce that address.

A fill notification carries the address of a line that has just been written into the cache. It marks every parked block with that address as eligible again. Eligible parked blocks take the cache port ahead of the predictor, oldest tag first, and leave with their original tags. Blocks therefore leave out of program order, and a later stage sorts them back by tag. A flush empties the table and loads the tag counter with a supplied value.

Top module: `fetch_skip_seq`

## Requirements
- R1: The cache probe for a predictor block is made in the cycle the block is offered, and `ic_hit` is the cache's answer for the address on `ic_req_addr` in that same cycle. When a predictor block is accepted and hits, it appears on the outputs in the next cycle, carrying the tag counter's value at acceptance. Every accepted predictor block advances the counter by one, modulo 2^TAG_W.
- R2: An accepted predictor block that misses is parked and is not delivered. Further predictor blocks are accepted in the following cycles without waiting for it.
- R3: A fill notification whose address matches a parked block makes that block eligible from the next cycle. While any parked block is eligible, it is sent to the cache and `pred_ready` is low. If it hits, it is delivered in the next cycle with the tag it was given when first accepted.
- R4: When several parked blocks are eligible, they are refetched in tag order, oldest first. Age is counted modulo 2^TAG_W back from the current counter, so a tag that has wrapped to 0 ranks after the tags 14 and 15 of a 4-bit tag.
- R5: At most DEPTH blocks are parked. While the table is full, a predictor block that misses is not accepted (`pred_ready` low) until a refetch frees an entry.
- R6: A refetched block that misses again stays parked and becomes eligible only after another matching fill notification.
- R7: While `flush` is high, `pred_ready` is low and nothing is sent to the cache. In the next cycle the table is empty, no block is delivered and the counter holds `flush_tag`. Fills for blocks parked before the flush produce no delivery.
- R8: No new predictor block is accepted while the counter is 2^TAG_W-1 ahead of the oldest parked tag, so tags in flight stay unique.
- R9: After reset the table is empty, the counter is 0, `out_valid` is low, and `ic_req_valid` stays low while no predictor block is offered and nothing is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pred_valid | input | 1 | Predictor offers a block address |
| pred_addr | input | AW | Predicted block address |
| pred_ready | output | 1 | Offered block is accepted this cycle |
| ic_req_valid | output | 1 | Cache probe valid |
| ic_req_addr | output | AW | Address probed in the cache |
| ic_hit | input | 1 | Same-cycle hit answer for the probe |
| fill_valid | input | 1 | A missed line has been filled |
| fill_addr | input | AW | Address of the filled line |
| flush | input | 1 | Discard parked blocks and reload the counter |
| flush_tag | input | TAG_W | Counter value loaded by a flush |
| out_valid | output | 1 | A fetched block is delivered |
| out_addr | output | AW | Address of the delivered block |
| out_tag | output | TAG_W | Program-order tag of the delivered block |

## Verification
The bench builds the block with AW=8, DEPTH=4 and TAG_W=4. The 4-bit tag lets a short run wrap the counter, so the oldest-first refetch order is checked across the 15-to-0 boundary. It also lets the bench reach the in-flight window limit after only fourteen hits behind one parked miss. With four table entries, the full-table stall is reached with a handful of misses, and the same cache model drives the re-miss case.

// File: rtl/fs_pkg.sv
package fs_pkg;
   // Which requester owns the cache port in the current cycle
   typedef enum logic [1:0] {
      SRC_NONE    = 2'd0,
      SRC_PRED    = 2'd1,
      SRC_REFETCH = 2'd2
   } fs_src_e;
endpackage

// File: rtl/fs_oldest_pick.sv
// Chooses, among requesting entries, the one whose tag lies furthest
// behind the running counter (modulo 2^TAG_W).
module fs_oldest_pick #(
   parameter int N     = 4,
   parameter int TAG_W = 6,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]            req,
   input  logic [N-1:0][TAG_W-1:0] tag,
   input  logic [TAG_W-1:0]        seq,
   output logic                    any,
   output logic [IDX_W-1:0]        idx
);
   logic [TAG_W-1:0] best_age;
   logic [TAG_W-1:0] age;

   always_comb begin
      any      = 1'b0;
      idx      = '0;
      best_age = '0;
      age      = '0;
      for (int i = 0; i < N; i++) begin
         age = seq - tag[i];
         if (req[i] && (!any || age > best_age)) begin
            any      = 1'b1;
            idx      = IDX_W'(i);
            best_age = age;
         end
      end
   end
endmodule

// File: rtl/fs_park_table.sv
// Storage for blocks that missed: address, tag, eligibility per entry.
module fs_park_table #(
   parameter int AW    = 32,
   parameter int DEPTH = 4,
   parameter int TAG_W = 6,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [TAG_W-1:0] seq,
   input  logic             alloc_en,
   input  logic [AW-1:0]    alloc_addr,
   input  logic [TAG_W-1:0] alloc_tag,
   input  logic             done_en,
   input  logic             retry_en,
   input  logic             fill_valid,
   input  logic [AW-1:0]    fill_addr,
   output logic             any_rdy,
   output logic [AW-1:0]    sel_addr,
   output logic [TAG_W-1:0] sel_tag,
   output logic             full,
   output logic             win_full
);
   logic [DEPTH-1:0]            vld_q, rdy_q;
   logic [DEPTH-1:0][AW-1:0]    addr_q;
   logic [DEPTH-1:0][TAG_W-1:0] tag_q;
   logic [IDX_W-1:0]            sel_idx, free_idx;
   logic [DEPTH-1:0]            win_hit;

   fs_oldest_pick #(.N(DEPTH), .TAG_W(TAG_W)) u_pick (
      .req (vld_q & rdy_q),
      .tag (tag_q),
      .seq (seq),
      .any (any_rdy),
      .idx (sel_idx)
   );

   assign sel_addr = addr_q[sel_idx];
   assign sel_tag  = tag_q[sel_idx];
   assign full     = &vld_q;
   assign win_full = |win_hit;

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) free_idx = IDX_W'(i);
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      // counter sits 2^TAG_W-1 ahead of this entry's tag
      assign win_hit[g] = vld_q[g] && ((seq - tag_q[g]) == {TAG_W{1'b1}});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[g]  <= 1'b0;
            rdy_q[g]  <= 1'b0;
            addr_q[g] <= '0;
            tag_q[g]  <= '0;
         end else if (flush) begin
            vld_q[g] <= 1'b0;
            rdy_q[g] <= 1'b0;
         end else if (alloc_en && free_idx == IDX_W'(g)) begin
            vld_q[g]  <= 1'b1;
            rdy_q[g]  <= fill_valid && (fill_addr == alloc_addr);
            addr_q[g] <= alloc_addr;
            tag_q[g]  <= alloc_tag;
         end else if (done_en && sel_idx == IDX_W'(g)) begin
            vld_q[g] <= 1'b0;
            rdy_q[g] <= 1'b0;
         end else if (vld_q[g]) begin
            if (fill_valid && fill_addr == addr_q[g]) rdy_q[g] <= 1'b1;
            else if (retry_en && sel_idx == IDX_W'(g)) rdy_q[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fetch_skip_seq.sv
module fetch_skip_seq #(
   parameter int AW    = 32,
   parameter int DEPTH = 4,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pred_valid,
   input  logic [AW-1:0]    pred_addr,
   output logic             pred_ready,
   output logic             ic_req_valid,
   output logic [AW-1:0]    ic_req_addr,
   input  logic             ic_hit,
   input  logic             fill_valid,
   input  logic [AW-1:0]    fill_addr,
   input  logic             flush,
   input  logic [TAG_W-1:0] flush_tag,
   output logic             out_valid,
   output logic [AW-1:0]    out_addr,
   output logic [TAG_W-1:0] out_tag
);
   import fs_pkg::*;

   if (AW < 1) begin : g_bad_aw
      $error("AW must be at least 1");
   end
   if (TAG_W < 2) begin : g_bad_tag
      $error("TAG_W must be at least 2");
   end
   if (DEPTH < 1 || DEPTH >= (1 << TAG_W) - 1) begin : g_bad_depth
      $error("DEPTH must be between 1 and 2^TAG_W-2");
   end

   logic [TAG_W-1:0] seq_q;
   logic             any_rdy, park_full, win_full;
   logic [AW-1:0]    sel_addr;
   logic [TAG_W-1:0] sel_tag;
   fs_src_e          src;
   logic             accept, refetch;

   always_comb begin
      if (flush)                       src = SRC_NONE;
      else if (any_rdy)                src = SRC_REFETCH;
      else if (pred_valid && !win_full) src = SRC_PRED;
      else                             src = SRC_NONE;
   end

   assign refetch      = (src == SRC_REFETCH);
   assign ic_req_valid = (src != SRC_NONE);
   assign ic_req_addr  = refetch ? sel_addr : pred_addr;
   assign pred_ready   = !flush && !any_rdy && !win_full && (ic_hit || !park_full);
   assign accept       = pred_valid && pred_ready;

   fs_park_table #(.AW(AW), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .seq        (seq_q),
      .alloc_en   (accept && !ic_hit),
      .alloc_addr (pred_addr),
      .alloc_tag  (seq_q),
      .done_en    (refetch && ic_hit),
      .retry_en   (refetch && !ic_hit),
      .fill_valid (fill_valid),
      .fill_addr  (fill_addr),
      .any_rdy    (any_rdy),
      .sel_addr   (sel_addr),
      .sel_tag    (sel_tag),
      .full       (park_full),
      .win_full   (win_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q     <= '0;
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_tag   <= '0;
      end else begin
         if (flush)       seq_q <= flush_tag;
         else if (accept) seq_q <= seq_q + 1'b1;
         out_valid <= !flush && (accept || refetch) && ic_hit;
         if (!flush && (accept || refetch) && ic_hit) begin
            out_addr <= ic_req_addr;
            out_tag  <= refetch ? sel_tag : seq_q;
         end
      end
   end
endmodule

// File: rtl/fetch_skip_seq_chk.sv
module fetch_skip_seq_chk #(
   parameter int TAG_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pred_valid,
   input logic             pred_ready,
   input logic             ic_req_valid,
   input logic             ic_hit,
   input logic             flush,
   input logic [TAG_W-1:0] flush_tag,
   input logic             out_valid,
   input logic [TAG_W-1:0] seq_q,
   input logic             any_rdy,
   input logic             park_full
);
   // R1
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && pred_ready) |=> seq_q == TAG_W'($past(seq_q) + 1'b1));

   // R1
   out_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(ic_req_valid && ic_hit && !flush));

   // R3
   refetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_rdy |-> !pred_ready);

   // R5
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (park_full && !ic_hit) |-> !pred_ready);

   // R7
   flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!pred_ready && !ic_req_valid));

   // R7
   flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (seq_q == $past(flush_tag) && !out_valid && !any_rdy));
endmodule

bind fetch_skip_seq fetch_skip_seq_chk #(.TAG_W(TAG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pred_valid   (pred_valid),
   .pred_ready   (pred_ready),
   .ic_req_valid (ic_req_valid),
   .ic_hit       (ic_hit),
   .flush        (flush),
   .flush_tag    (flush_tag),
   .out_valid    (out_valid),
   .seq_q        (seq_q),
   .any_rdy      (any_rdy),
   .park_full    (park_full)
);

// File: tb/fetch_skip_seq_tb.sv
`timescale 1ns/1ps
module fetch_skip_seq_tb;
   localparam int AW = 8, DEPTH = 4, TAG_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pred_valid = 1'b0, fill_valid = 1'b0, flush = 1'b0;
   logic [AW-1:0] pred_addr = '0, fill_addr = '0;
   logic [TAG_W-1:0] flush_tag = '0;
   logic pred_ready, ic_req_valid, ic_hit, out_valid;
   logic [AW-1:0] ic_req_addr, out_addr;
   logic [TAG_W-1:0] out_tag;
   logic [255:0] miss_map = '0;

   int total = 0, fails = 0, rec_n = 0;
   int rec_addr [64];
   int rec_tag  [64];

   always #10 clk = ~clk;

   // cache model: answers in the cycle of the probe
   assign ic_hit = !miss_map[ic_req_addr];

   fetch_skip_seq #(.AW(AW), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_addr(pred_addr),
      .pred_ready(pred_ready), .ic_req_valid(ic_req_valid), .ic_req_addr(ic_req_addr),
      .ic_hit(ic_hit), .fill_valid(fill_valid), .fill_addr(fill_addr), .flush(flush),
      .flush_tag(flush_tag), .out_valid(out_valid), .out_addr(out_addr), .out_tag(out_tag)
   );

   always @(negedge clk) begin
      if (out_valid && rec_n < 64) begin
         rec_addr[rec_n] = int'(out_addr);
         rec_tag[rec_n]  = int'(out_tag);
         rec_n++;
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic chk_rec(input int i, input string rq, input int a, input int t);
      chk(rec_addr[i] == a, rq, rec_addr[i], a);
      chk(rec_tag[i] == t, rq, rec_tag[i], t);
   endtask

   task automatic push(input int a, output int waits);
      waits = 0;
      @(negedge clk);
      pred_valid = 1'b1;
      pred_addr  = AW'(a);
      #2;
      while (!pred_ready) begin
         @(negedge clk);
         #2;
         waits++;
      end
      @(posedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      pred_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic fill(input int a, input bit clear);
      @(negedge clk);
      pred_valid = 1'b0;
      fill_valid = 1'b1;
      fill_addr  = AW'(a);
      if (clear) miss_map[a] = 1'b0;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic do_flush(input int t);
      @(negedge clk);
      flush      = 1'b1;
      flush_tag  = TAG_W'(t);
      pred_valid = 1'b1;
      pred_addr  = 8'h99;
      #2;
      // R7: nothing accepted or probed during a flush
      chk(!pred_ready, "R7 pred_ready during flush", int'(pred_ready), 0);
      chk(!ic_req_valid, "R7 probe during flush", int'(ic_req_valid), 0);
      @(negedge clk);
      flush      = 1'b0;
      pred_valid = 1'b0;
   endtask

   task automatic t_reset();
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9
      chk(!out_valid, "R9 out_valid after reset", int'(out_valid), 0);
      chk(!ic_req_valid, "R9 no probe when idle", int'(ic_req_valid), 0);
      push(8'h10, w);
      idle(2);
      chk(rec_n == 1, "R9 first delivery", rec_n, 1);
      chk_rec(0, "R9 counter starts at zero", 8'h10, 0);
   endtask

   task automatic t_hits();
      int w, base;
      base = rec_n;
      push(8'h11, w);
      push(8'h12, w);
      push(8'h13, w);
      idle(2);
      // R1
      chk(rec_n - base == 3, "R1 hit count", rec_n - base, 3);
      chk_rec(base,     "R1 hit stream", 8'h11, 1);
      chk_rec(base + 1, "R1 hit stream", 8'h12, 2);
      chk_rec(base + 2, "R1 hit stream", 8'h13, 3);
   endtask

   task automatic t_miss_skip();
      int w, base;
      base = rec_n;
      miss_map[8'h40] = 1'b1;
      push(8'h40, w);
      push(8'h41, w);
      chk(w == 0, "R2 no wait after a miss", w, 0);
      push(8'h42, w);
      idle(2);
      // R2: missed block skipped, followers delivered
      chk(rec_n - base == 2, "R2 skipped block held", rec_n - base, 2);
      chk_rec(base,     "R2 follower", 8'h41, 5);
      chk_rec(base + 1, "R2 follower", 8'h42, 6);
      fill(8'h40, 1'b1);
      pred_valid = 1'b1;
      pred_addr  = 8'h43;
      #2;
      // R3: refetch wins the port
      chk(!pred_ready, "R3 refetch priority", int'(pred_ready), 0);
      @(negedge clk);
      #2;
      chk(pred_ready, "R3 predictor resumes", int'(pred_ready), 1);
      @(posedge clk);
      idle(2);
      chk(rec_n - base == 4, "R3 delivery count", rec_n - base, 4);
      chk_rec(base + 2, "R3 refetched keeps tag", 8'h40, 4);
      chk_rec(base + 3, "R3 next predictor block", 8'h43, 7);
   endtask

   task automatic t_order();
      int w, base;
      do_flush(14);
      base = rec_n;
      miss_map[8'h60] = 1'b1;
      push(8'h60, w);
      push(8'h60, w);
      push(8'h60, w);
      idle(1);
      fill(8'h60, 1'b1);
      idle(4);
      // R4: oldest first across the wrap
      chk(rec_n - base == 3, "R4 count", rec_n - base, 3);
      chk_rec(base,     "R4 order", 8'h60, 14);
      chk_rec(base + 1, "R4 order", 8'h60, 15);
      chk_rec(base + 2, "R4 order", 8'h60, 0);
   endtask

   task automatic t_full();
      int w, base, got;
      base = rec_n;
      for (int i = 0; i < 5; i++) miss_map[8'h70 + i] = 1'b1;
      for (int i = 0; i < 4; i++) push(8'h70 + i, w);
      @(negedge clk);
      pred_valid = 1'b1;
      pred_addr  = 8'h74;
      #2;
      // R5
      chk(!pred_ready, "R5 stall when full", int'(pred_ready), 0);
      repeat (2) @(negedge clk);
      #2;
      chk(!pred_ready, "R5 stall persists", int'(pred_ready), 0);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_addr  = 8'h71;
      miss_map[8'h71] = 1'b0;
      @(negedge clk);
      fill_valid = 1'b0;
      got = 0;
      for (int i = 0; i < 6; i++) begin
         #2;
         if (pred_ready && got == 0) got = 1;
         if (got == 1) begin
            @(posedge clk);
            got = 2;
         end
         @(negedge clk);
      end
      pred_valid = 1'b0;
      chk(got == 2, "R5 released slot accepts", got, 2);
      chk(rec_n - base == 1, "R5 freed entry delivered", rec_n - base, 1);
      chk_rec(base, "R5 freed entry", 8'h71, 2);
      // R6: refetch misses again
      base = rec_n;
      fill(8'h72, 1'b0);
      idle(4);
      chk(rec_n == base, "R6 re-miss not delivered", rec_n - base, 0);
      fill(8'h72, 1'b1);
      idle(3);
      chk(rec_n - base == 1, "R6 second fill delivers", rec_n - base, 1);
      chk_rec(base, "R6 delivered", 8'h72, 3);
   endtask

   task automatic t_flush();
      int base;
      do_flush(9);
      base = rec_n;
      fill(8'h70, 1'b1);
      fill(8'h73, 1'b1);
      fill(8'h74, 1'b1);
      idle(3);
      // R7: parked blocks discarded
      chk(rec_n == base, "R7 flushed blocks gone", rec_n - base, 0);
   endtask

   task automatic t_window();
      int w, acc, base;
      bit stop;
      miss_map[8'h80] = 1'b1;
      push(8'h80, w);
      acc  = 0;
      stop = 1'b0;
      for (int k = 0; k < 20; k++) begin
         if (!stop) begin
            @(negedge clk);
            pred_valid = 1'b1;
            pred_addr  = AW'(k + 1);
            #2;
            if (!pred_ready) stop = 1'b1;
            else begin
               @(posedge clk);
               acc++;
            end
         end
      end
      // R8: counter 9 after flush, tag 9 parked, 14 more fit
      chk(acc == 14, "R8 window limit", acc, 14);
      base = rec_n;
      fill(8'h80, 1'b1);
      idle(2);
      chk(rec_n - base == 1, "R8 oldest delivered", rec_n - base, 1);
      chk_rec(base, "R8 oldest tag", 8'h80, 9);
      @(negedge clk);
      pred_valid = 1'b1;
      pred_addr  = 8'h30;
      #2;
      chk(pred_ready, "R8 window reopens", int'(pred_ready), 1);
      idle(1);
   endtask

   initial begin
      t_reset();
      t_hits();
      t_miss_skip();
      t_order();
      t_full();
      t_flush();
      t_window();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule